// File: doc/BRIEF.md
# Retentive Edge-Triggered Up Counter

This block is a count-up element of the kind found in programmable logic controllers, built as hardware. A scan strobe marks the moments at which the count-enable input is looked at. The block remembers the enable value from the previous strobe. When a strobe finds the enable high after it was low, the 16-bit signed accumulator goes up by one. An enable held high across many strobes therefore gives a single count.

The accumulator is retentive. It holds its value through any number of low-enable scans and changes back to zero only when the synchronous clear input is asserted. A done flag compares the accumulator against a programmable preset with a signed greater-or-equal test. Counting does not stop at the preset, and done simply stays asserted. When an increment passes +32767, the accumulator wraps to -32768 and a sticky overflow flag is set.

Two things are needed to use the block. The scan strobe must be a one-cycle pulse, and the clear input must be asserted once before the first scan, because clear also acts as the initialising reset. The enable and clear are plain level controls and the preset is a static configuration word, so there is no stream handshake and no back-pressure.

Top module: `edge_count_up`

## Requirements
- R1: On a cycle with `scan` high and `clr` low, when `cnt_en` is 1 and `cu` is 0, `acc` increases by exactly one. An enable that stays high over consecutive strobes adds no further counts.
- R2: `cnt_en` is sampled only in cycles where `scan` is high. In a cycle with `scan` and `clr` both low, `acc`, `cu` and `ov` do not change. As a result, a pulse that lies wholly between two strobes is not counted, and several pulses between two strobes give at most one edge.
- R3: `dn` is 1 exactly when `acc` is greater than or equal to `preset`, with both treated as two's-complement signed values. `dn` follows a change of `preset` in the same cycle, with no clock edge needed.
- R4: When `acc` is at or above `preset`, further rising edges keep incrementing `acc`, and `dn` stays at 1.
- R5: A low `cnt_en` never clears `acc`. The count is held across any number of low-enable strobes.
- R6: `cu` equals the value of `cnt_en` captured at the most recent strobe or clear.
- R7: A rising edge counted while `acc` is 32767 loads -32768 (0x8000) into `acc` and sets `ov`. `ov` then stays at 1 through later counts until a clear. `ov` is 0 while `acc` has not yet wrapped.
- R8: `clr` is synchronous and wins over a coincident edge. It sets `acc` to 0 and `ov` to 0, and loads `cu` and the edge history with the current `cnt_en`. An enable that is already high at clear is therefore not counted on the next strobe.
- R9: `acc`, `cu` and `ov` change at the clock edge that ends the strobe cycle, and `dn` reflects the new `acc` from that same edge. During the strobe cycle, before that edge, the outputs still show the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear and initialising reset, active high |
| scan | input | 1 | One-cycle scan strobe; the enable is sampled only here |
| cnt_en | input | 1 | Count enable condition |
| preset | input | 16 | Signed preset for the done comparison |
| acc | output | 16 | Signed accumulator |
| cu | output | 1 | Enable value captured at the last strobe |
| dn | output | 1 | Accumulator is at or above the preset |
| ov | output | 1 | Sticky overflow flag |

## Verification
The bench checks the following corner cases, each of which catches a specific kind of wrong design:
- A long high enable must give one count. A design that counts levels instead of edges would run away.
- A pulse raised and dropped between strobes must be lost. A design that samples on every clock would count it.
- A clear that coincides with a rising edge, with the enable still high afterwards, must leave the accumulator at zero. A design that gives the edge priority, or that does not reload the edge history at clear, would show one.
- The count is driven past the preset and then through +32767. A design using an equality compare for done, an unsigned compare, or a non-sticky or saturating overflow would show the wrong done flag, the wrong value after wrap, or the wrong flag after wrap.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  // Next-state choice for the accumulator register
  typedef enum logic [1:0] {
    ACC_HOLD  = 2'd0,
    ACC_CLEAR = 2'd1,
    ACC_INC   = 2'd2,
    ACC_WRAP  = 2'd3
  } acc_op_t;

endpackage

// File: rtl/ecu_sampler.sv
// Captures the enable once per strobe and flags a low-to-high change.
module ecu_sampler (
  input  logic clk,
  input  logic clr,
  input  logic scan,
  input  logic en_in,
  output logic en_q,
  output logic rise
);

  logic hist_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      hist_q <= en_in;
    end else if (scan) begin
      hist_q <= en_in;
    end
  end

  always_comb begin
    rise = scan & en_in & ~hist_q & ~clr;
    en_q = hist_q;
  end

endmodule

// File: rtl/ecu_accum.sv
// Retentive accumulator with wrap and sticky overflow.
module ecu_accum
  import ecu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    rise,
  output logic signed [WIDTH-1:0] acc_q,
  output logic                    ovf_q
);

  localparam logic signed [WIDTH-1:0] ACC_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] ACC_MIN = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic signed [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  acc_op_t op;
  logic    at_max;

  always_comb begin
    at_max = (acc_q == ACC_MAX);
    if (clr)         op = ACC_CLEAR;
    else if (!rise)  op = ACC_HOLD;
    else if (at_max) op = ACC_WRAP;
    else             op = ACC_INC;
  end

  always_ff @(posedge clk) begin
    unique case (op)
      ACC_CLEAR: begin
        acc_q <= '0;
        ovf_q <= 1'b0;
      end
      ACC_INC: begin
        acc_q <= acc_q + ONE;
      end
      ACC_WRAP: begin
        acc_q <= ACC_MIN;
        ovf_q <= 1'b1;
      end
      default: begin
        acc_q <= acc_q;
        ovf_q <= ovf_q;
      end
    endcase
  end

endmodule

// File: rtl/ecu_compare.sv
// Signed greater-or-equal test of the count against the preset.
module ecu_compare #(
  parameter int WIDTH = 16
) (
  input  logic signed [WIDTH-1:0] value,
  input  logic signed [WIDTH-1:0] limit,
  output logic                    at_or_above
);

  always_comb begin
    at_or_above = (value >= limit);
  end

endmodule

// File: rtl/edge_count_up.sv
module edge_count_up #(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    scan,
  input  logic                    cnt_en,
  input  logic signed [WIDTH-1:0] preset,
  output logic signed [WIDTH-1:0] acc,
  output logic                    cu,
  output logic                    dn,
  output logic                    ov
);

  logic rise;

  ecu_sampler u_sampler (
    .clk   (clk),
    .clr   (clr),
    .scan  (scan),
    .en_in (cnt_en),
    .en_q  (cu),
    .rise  (rise)
  );

  ecu_accum #(.WIDTH(WIDTH)) u_accum (
    .clk   (clk),
    .clr   (clr),
    .rise  (rise),
    .acc_q (acc),
    .ovf_q (ov)
  );

  ecu_compare #(.WIDTH(WIDTH)) u_compare (
    .value       (acc),
    .limit       (preset),
    .at_or_above (dn)
  );

endmodule

// File: rtl/edge_count_up_chk.sv
module edge_count_up_chk #(
  parameter int WIDTH = 16
) (
  input logic                    clk,
  input logic                    clr,
  input logic                    scan,
  input logic                    cnt_en,
  input logic signed [WIDTH-1:0] preset,
  input logic signed [WIDTH-1:0] acc,
  input logic                    cu,
  input logic                    dn,
  input logic                    ov
);

  localparam logic signed [WIDTH-1:0] TOP = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] BOT = {1'b1, {(WIDTH-1){1'b0}}};

  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    (scan && cnt_en && !cu && acc != TOP) |=> (acc == $past(acc) + 1'b1));

  // R1
  held_high_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    (scan && cnt_en && cu) |=> $stable(acc));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    (!scan) |=> ($stable(acc) && $stable(cu) && $stable(ov)));

  // R6
  cu_follow_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    scan |=> (cu == $past(cnt_en)));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    (scan && cnt_en && !cu && acc == TOP) |=> (acc == BOT && ov));

  // R7
  ov_sticky_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    ov |=> ov);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (acc == '0 && !ov && cu == $past(cnt_en)));

endmodule

bind edge_count_up edge_count_up_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .clr    (clr),
  .scan   (scan),
  .cnt_en (cnt_en),
  .preset (preset),
  .acc    (acc),
  .cu     (cu),
  .dn     (dn),
  .ov     (ov)
);

// File: tb/edge_count_up_test.sv
`timescale 1ns/1ps
module edge_count_up_test;

  logic               clk = 1'b0;
  logic               clr = 1'b0;
  logic               scan = 1'b0;
  logic               cnt_en = 1'b0;
  logic signed [15:0] preset = 16'sd3;
  logic signed [15:0] acc;
  logic               cu, dn, ov;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  edge_count_up uut (
    .clk(clk), .clr(clr), .scan(scan), .cnt_en(cnt_en), .preset(preset),
    .acc(acc), .cu(cu), .dn(dn), .ov(ov)
  );

  // {clr, scan, en, exp_acc[15:0], exp_cu, exp_dn, exp_ov}, preset = 3
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {3'b100, 16'd0, 3'b000},  // R8 initial clear
    {3'b011, 16'd1, 3'b100},  // R1 first edge
    {3'b011, 16'd1, 3'b100},  // R1 held high, no count
    {3'b000, 16'd1, 3'b100},  // R2 no strobe
    {3'b001, 16'd1, 3'b100},  // R2 no strobe
    {3'b010, 16'd1, 3'b000},  // R6 low sampled
    {3'b001, 16'd1, 3'b000},  // R2 sub-scan pulse start
    {3'b000, 16'd1, 3'b000},  // R2 sub-scan pulse end
    {3'b010, 16'd1, 3'b000},  // R2 pulse missed
    {3'b011, 16'd2, 3'b100},  // R1 second edge
    {3'b010, 16'd2, 3'b000},  // R5 retained
    {3'b011, 16'd3, 3'b110},  // R3 reach preset
    {3'b010, 16'd3, 3'b010},  // R5 retained with dn
    {3'b011, 16'd4, 3'b110},  // R4 past preset
    {3'b111, 16'd0, 3'b100},  // R8 clear beats edge
    {3'b011, 16'd0, 3'b100},  // R8 high at clear not counted
    {3'b010, 16'd0, 3'b000},  // R6
    {3'b011, 16'd1, 3'b100}   // R1 counting again
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic c, logic s, logic e);
    @(negedge clk);
    clr = c; scan = s; cnt_en = e;
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19]);
      check($sformatf("R1/R2/R4/R5/R8 acc vec %0d", i), acc, VEC[i][18:3]);
      check($sformatf("R6 cu vec %0d", i), {15'd0, cu}, {15'd0, VEC[i][2]});
      check($sformatf("R3 dn vec %0d", i), {15'd0, dn}, {15'd0, VEC[i][1]});
      check($sformatf("R7 ov vec %0d", i), {15'd0, ov}, {15'd0, VEC[i][0]});
    end

    // R3: signed compare, follows preset without a clock edge (acc = 1)
    @(negedge clk); clr = 0; scan = 0; preset = -16'sd5; #2;
    check("R3 dn negative preset", {15'd0, dn}, 16'd1);
    preset = 16'sd2; #2;
    check("R3 dn preset above acc", {15'd0, dn}, 16'd0);
    preset = 16'sd1; #2;
    check("R3 dn preset equal", {15'd0, dn}, 16'd1);

    // R9: no change before the edge that ends the strobe cycle
    step(0, 1, 0);
    @(negedge clk); scan = 1; cnt_en = 1; #2;
    check("R9 acc before edge", acc, 16'd1);
    @(posedge clk); #2;
    check("R9 acc after edge", acc, 16'd2);
    check("R9 dn after edge", {15'd0, dn}, 16'd1);

    // R7: count up to the maximum, then wrap
    preset = 16'sd100;
    step(1, 0, 0);
    for (int k = 0; k < 32767; k++) begin
      step(0, 1, 1);
      step(0, 1, 0);
    end
    check("R7 acc at max", acc, 16'h7FFF);
    check("R7 ov before wrap", {15'd0, ov}, 16'd0);
    check("R4 dn at max", {15'd0, dn}, 16'd1);
    step(0, 1, 1);
    check("R7 acc wrapped", acc, 16'h8000);
    check("R7 ov set", {15'd0, ov}, 16'd1);
    check("R3 dn after wrap signed", {15'd0, dn}, 16'd0);
    step(0, 1, 0);
    step(0, 1, 1);
    check("R7 acc after wrap", acc, 16'h8001);
    check("R7 ov sticky", {15'd0, ov}, 16'd1);
    step(1, 0, 0);
    check("R8 ov cleared", {15'd0, ov}, 16'd0);
    check("R8 acc cleared", acc, 16'd0);

    summary();
    $finish;
  end

endmodule